// File: doc/BRIEF.md
# UART Character FIFO Control and Ready Signaling

This block holds the transmit and receive character queues of one UART channel and interprets writes to the channel's FIFO control byte. The serial shifters sit outside. The receive shifter pushes each finished character in, and the host side pops it. The host side pushes outgoing characters, and the transmit shifter pops them. A receive time-out pulse comes from the character-timing logic, which is also outside the block.

One control byte write does several things. It turns the queues on or off. It can empty either queue without touching the shifter that feeds or drains it. It selects a receive threshold and a transmit threshold from two small tables, and it selects how the two active-low ready pins behave. In the hysteretic pin mode, a ready pin asserts at a multi-character threshold and releases only at the opposite extreme. In the simple mode, the pins report whether a single character is present.

While the queues are off, each direction holds a single character. When the queues are on, each direction holds `DEPTH` characters. The fill levels, the threshold-reached flags, the overrun flags and the stored control value are brought out as ports.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset the queues are off and both levels are 0. `cfgValue` reads 0x00, `rxRdyN` is 1, `txRdyN` is 0 and both overrun flags are 0.
- R2: A control write with bit 0 = 0 clears the enable and programs nothing else. Bits 7:3 of `cfgValue` keep their values, and bits 1 and 2 of that write have no effect.
- R3: A control write with bit 0 = 1 stores the receive threshold code from bits 7:6, the transmit threshold code from bits 5:4 and the pin mode from bit 3 (1 = hysteretic). `cfgValue` then reads {bits 7:3 as stored, 2'b00, enable}.
- R4: In a write with bit 0 = 1, bit 1 empties the receive queue and bit 2 empties the transmit queue. The level of the emptied queue is 0 and its overrun flag is 0 on the next cycle. The other queue is untouched. Neither bit is stored.
- R5: Any change of the enable, in either direction, empties both queues.
- R6: The receive threshold is 8, 16, 56 or 60 for codes 00, 01, 10 and 11. `rxTrigHit` is 1 exactly when `rxLevel` is at or above the threshold.
- R7: The transmit threshold is 8, 16, 32 or 56 for codes 00, 01, 10 and 11. `txTrigHit` is 1 exactly when the free space (`DEPTH - txLevel`) is at or above the threshold.
- R8: With the queues on and hysteretic mode selected, `rxRdyN` falls when the receive level reaches its threshold or when `rxTimeout` pulses while characters are held. It then stays 0 until the receive queue is empty.
- R9: With the queues on and hysteretic mode selected, `txRdyN` rises when the transmit queue becomes full. It falls again once the free space reaches the transmit threshold.
- R10: Otherwise, `rxRdyN` is 0 exactly when the receive level is non-zero, and `txRdyN` is 1 exactly when the transmit level is non-zero.
- R11: A queue holds `DEPTH` characters while on and 1 while off. A push into a full queue that is not paired with a pop is dropped and sets that direction's sticky overrun flag.
- R12: Characters leave in arrival order. The pop data output loads the popped character on the clock edge of the pop. A pop from an empty queue leaves both the data output and the level unchanged.
- R13: A push and a pop in the same cycle on a non-empty queue leave its level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrite | input | 1 | Control byte write strobe |
| cfgData | input | 8 | Control byte written |
| cfgValue | output | 8 | Stored control value (reset bits read 0) |
| txPush | input | 1 | Host pushes a transmit character |
| txPushData | input | DATA_W | Transmit character pushed |
| txPop | input | 1 | Transmit shifter pops a character |
| txPopData | output | DATA_W | Last transmit character popped |
| rxPush | input | 1 | Receive shifter pushes a character |
| rxPushData | input | DATA_W | Receive character pushed |
| rxPop | input | 1 | Host pops a receive character |
| rxPopData | output | DATA_W | Last receive character popped |
| rxTimeout | input | 1 | Receive time-out pulse |
| txLevel | output | LVL_W | Transmit fill level |
| rxLevel | output | LVL_W | Receive fill level |
| txTrigHit | output | 1 | Transmit free space at or above threshold |
| rxTrigHit | output | 1 | Receive level at or above threshold |
| txRdyN | output | 1 | Active-low transmit ready pin |
| rxRdyN | output | 1 | Active-low receive ready pin |
| txOverrun | output | 1 | Sticky transmit overrun flag |
| rxOverrun | output | 1 | Sticky receive overrun flag |

## Verification
The bench builds the block with `DEPTH` = 64 and `DATA_W` = 8. At that depth every threshold code in both tables can be reached. This includes the 60-character receive threshold and the 8-free-slot point of a 64-deep transmit queue, so each threshold edge is measured one character below and at the edge itself. The same depth lets the bench fill a queue completely, which exercises the full-queue drop, the overrun flag and the release point of the transmit pin.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  // Strobes the control sends to the queue datapath; all already qualified.
  typedef struct packed {
    logic rxClear;
    logic txClear;
    logic rxWr;
    logic rxRd;
    logic txWr;
    logic txRd;
  } fifoStrobe_t;

  function automatic logic [7:0] rxTrigFor(input logic [1:0] code);
    case (code)
      2'b00:   return 8'd8;
      2'b01:   return 8'd16;
      2'b10:   return 8'd56;
      default: return 8'd60;
    endcase
  endfunction

  function automatic logic [7:0] txTrigFor(input logic [1:0] code);
    case (code)
      2'b00:   return 8'd8;
      2'b01:   return 8'd16;
      2'b10:   return 8'd32;
      default: return 8'd56;
    endcase
  endfunction

endpackage

// File: rtl/uart_char_fifo.sv
module uart_char_fifo #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [LVL_W-1:0]  level
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (wr) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      level  <= '0;
      rdData <= '0;
    end else if (clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (wr) wrPtr <= bump(wrPtr);
      if (rd) begin
        rdPtr  <= bump(rdPtr);
        rdData <= mem[rdPtr];
      end
      level <= level + LVL_W'(wr) - LVL_W'(rd);
    end
  end

  // R11: the level never passes the physical depth
  assert_level_bound_R11: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH));

  // R12: the control never pops a queue that is empty
  assert_pop_nonempty_R12: assert property (@(posedge clk) disable iff (!rstN)
    rd |-> level != '0);

endmodule

// File: rtl/uart_fifo_datapath.sv
module uart_fifo_datapath import uart_fifo_pkg::*; #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic [DATA_W-1:0] txPushData,
  input  logic [DATA_W-1:0] rxPushData,
  output logic [DATA_W-1:0] txPopData,
  output logic [DATA_W-1:0] rxPopData,
  output logic [LVL_W-1:0]  txLevel,
  output logic [LVL_W-1:0]  rxLevel
);

  uart_char_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_txFifo (
    .clk    (clk),
    .rstN   (rstN),
    .clear  (strobe.txClear),
    .wr     (strobe.txWr),
    .rd     (strobe.txRd),
    .wrData (txPushData),
    .rdData (txPopData),
    .level  (txLevel)
  );

  uart_char_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_rxFifo (
    .clk    (clk),
    .rstN   (rstN),
    .clear  (strobe.rxClear),
    .wr     (strobe.rxWr),
    .rd     (strobe.rxRd),
    .wrData (rxPushData),
    .rdData (rxPopData),
    .level  (rxLevel)
  );

endmodule

// File: rtl/uart_fifo_control.sv
module uart_fifo_control import uart_fifo_pkg::*; #(
  parameter int DEPTH  = 64,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrite,
  input  logic [7:0]       cfgData,
  input  logic             txPush,
  input  logic             txPop,
  input  logic             rxPush,
  input  logic             rxPop,
  input  logic             rxTimeout,
  input  logic [LVL_W-1:0] txLevel,
  input  logic [LVL_W-1:0] rxLevel,
  output fifoStrobe_t      strobe,
  output logic [7:0]       cfgValue,
  output logic             txTrigHit,
  output logic             rxTrigHit,
  output logic             txRdyN,
  output logic             rxRdyN,
  output logic             txOverrun,
  output logic             rxOverrun
);

  localparam logic [LVL_W-1:0] FULL_CAP = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] ONE_CAP  = LVL_W'(1);

  // Stored control state
  logic       fifoOn, modeOne;
  logic [1:0] rxSel, txSel;
  logic       fifoOnNext, modeOneNext;
  logic [1:0] rxSelNext, txSelNext;

  // Hysteretic pin state
  logic rxHold, txHigh;
  logic rxHoldNext, txHighNext;

  logic             wrEnable, enToggle;
  logic             rxClear, txClear;
  logic [LVL_W-1:0] cap, capNext;
  logic [LVL_W-1:0] rxTrig, txTrig, rxTrigNext, txTrigNext;
  logic             rxWr, rxRd, txWr, txRd;
  logic [LVL_W-1:0] rxLvlNext, txLvlNext, txFreeNext;
  logic             pinModeOne;

  // Control byte decode: a write without the enable bit only clears the enable
  always_comb begin
    fifoOnNext  = fifoOn;
    modeOneNext = modeOne;
    rxSelNext   = rxSel;
    txSelNext   = txSel;
    if (cfgWrite) begin
      if (cfgData[0]) begin
        fifoOnNext  = 1'b1;
        rxSelNext   = cfgData[7:6];
        txSelNext   = cfgData[5:4];
        modeOneNext = cfgData[3];
      end else begin
        fifoOnNext  = 1'b0;
      end
    end
  end

  assign wrEnable = cfgWrite && cfgData[0];
  assign enToggle = fifoOnNext != fifoOn;
  assign rxClear  = enToggle || (wrEnable && cfgData[1]);
  assign txClear  = enToggle || (wrEnable && cfgData[2]);

  assign cap     = fifoOn     ? FULL_CAP : ONE_CAP;
  assign capNext = fifoOnNext ? FULL_CAP : ONE_CAP;

  assign rxTrig     = LVL_W'(rxTrigFor(rxSel));
  assign txTrig     = LVL_W'(txTrigFor(txSel));
  assign rxTrigNext = LVL_W'(rxTrigFor(rxSelNext));
  assign txTrigNext = LVL_W'(txTrigFor(txSelNext));

  // Push/pop qualification; a clear in the same cycle wins over both
  assign rxRd = rxPop && (rxLevel != '0) && !rxClear;
  assign rxWr = rxPush && ((rxLevel < cap) || rxRd) && !rxClear;
  assign txRd = txPop && (txLevel != '0) && !txClear;
  assign txWr = txPush && ((txLevel < cap) || txRd) && !txClear;

  always_comb begin
    strobe.rxClear = rxClear;
    strobe.txClear = txClear;
    strobe.rxWr    = rxWr;
    strobe.rxRd    = rxRd;
    strobe.txWr    = txWr;
    strobe.txRd    = txRd;
  end

  assign rxLvlNext  = rxClear ? '0 : rxLevel + LVL_W'(rxWr) - LVL_W'(rxRd);
  assign txLvlNext  = txClear ? '0 : txLevel + LVL_W'(txWr) - LVL_W'(txRd);
  assign txFreeNext = capNext - txLvlNext;

  // Receive pin: set at threshold or time-out, held until the queue drains
  assign rxHoldNext = (rxLvlNext != '0) &&
                      (rxHold || (rxLvlNext >= rxTrigNext) || rxTimeout);

  // Transmit pin: high once full, low again once enough room is free
  always_comb begin
    if (txLvlNext >= capNext)          txHighNext = 1'b1;
    else if (txFreeNext >= txTrigNext) txHighNext = 1'b0;
    else                               txHighNext = txHigh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoOn    <= 1'b0;
      modeOne   <= 1'b0;
      rxSel     <= 2'b00;
      txSel     <= 2'b00;
      rxHold    <= 1'b0;
      txHigh    <= 1'b0;
      rxOverrun <= 1'b0;
      txOverrun <= 1'b0;
    end else begin
      fifoOn  <= fifoOnNext;
      modeOne <= modeOneNext;
      rxSel   <= rxSelNext;
      txSel   <= txSelNext;
      rxHold  <= rxHoldNext;
      txHigh  <= txHighNext;
      if (rxClear)                rxOverrun <= 1'b0;
      else if (rxPush && !rxWr)   rxOverrun <= 1'b1;
      if (txClear)                txOverrun <= 1'b0;
      else if (txPush && !txWr)   txOverrun <= 1'b1;
    end
  end

  assign pinModeOne = fifoOn && modeOne;
  assign rxRdyN     = pinModeOne ? !rxHold : (rxLevel == '0);
  assign txRdyN     = pinModeOne ? txHigh  : (txLevel != '0);
  assign rxTrigHit  = rxLevel >= rxTrig;
  assign txTrigHit  = (FULL_CAP - txLevel) >= txTrig;
  assign cfgValue   = {rxSel, txSel, modeOne, 2'b00, fifoOn};

  // R2: a write without the enable bit leaves the programmed fields alone
  assert_ignored_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite && !cfgData[0] |=> $stable(cfgValue[7:3]) && !cfgValue[0]);

  // R4: receive reset bit empties the receive queue
  assert_rx_reset_R4: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite && cfgData[0] && cfgData[1] |=> rxLevel == '0);

  // R4: transmit reset bit empties the transmit queue
  assert_tx_reset_R4: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite && cfgData[0] && cfgData[2] |=> txLevel == '0);

  // R8: in hysteretic mode the receive pin is never active on an empty queue
  assert_rx_pin_empty_R8: assert property (@(posedge clk) disable iff (!rstN)
    pinModeOne && rxLevel == '0 |-> rxRdyN);

  // R9: in hysteretic mode a full transmit queue holds the pin high
  assert_tx_pin_full_R9: assert property (@(posedge clk) disable iff (!rstN)
    pinModeOne && txLevel == FULL_CAP |-> txRdyN);

  // R11: an unpaired push into a full enabled queue raises the overrun flag
  assert_rx_overrun_R11: assert property (@(posedge clk) disable iff (!rstN)
    fifoOn && !cfgWrite && rxPush && !rxPop && rxLevel == FULL_CAP |=> rxOverrun);

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl import uart_fifo_pkg::*; #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrite,
  input  logic [7:0]        cfgData,
  output logic [7:0]        cfgValue,
  input  logic              txPush,
  input  logic [DATA_W-1:0] txPushData,
  input  logic              txPop,
  output logic [DATA_W-1:0] txPopData,
  input  logic              rxPush,
  input  logic [DATA_W-1:0] rxPushData,
  input  logic              rxPop,
  output logic [DATA_W-1:0] rxPopData,
  input  logic              rxTimeout,
  output logic [LVL_W-1:0]  txLevel,
  output logic [LVL_W-1:0]  rxLevel,
  output logic              txTrigHit,
  output logic              rxTrigHit,
  output logic              txRdyN,
  output logic              rxRdyN,
  output logic              txOverrun,
  output logic              rxOverrun
);

  fifoStrobe_t strobe;

  uart_fifo_control #(.DEPTH(DEPTH)) i_control (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrite  (cfgWrite),
    .cfgData   (cfgData),
    .txPush    (txPush),
    .txPop     (txPop),
    .rxPush    (rxPush),
    .rxPop     (rxPop),
    .rxTimeout (rxTimeout),
    .txLevel   (txLevel),
    .rxLevel   (rxLevel),
    .strobe    (strobe),
    .cfgValue  (cfgValue),
    .txTrigHit (txTrigHit),
    .rxTrigHit (rxTrigHit),
    .txRdyN    (txRdyN),
    .rxRdyN    (rxRdyN),
    .txOverrun (txOverrun),
    .rxOverrun (rxOverrun)
  );

  uart_fifo_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .txPushData (txPushData),
    .rxPushData (rxPushData),
    .txPopData  (txPopData),
    .rxPopData  (rxPopData),
    .txLevel    (txLevel),
    .rxLevel    (rxLevel)
  );

endmodule

// File: tb/test_uart_fifo_ctrl.sv
module test_uart_fifo_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;
  localparam int DATA_W     = 8;
  localparam int LVL_W      = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWrite = 1'b0;
  logic [7:0]        cfgData = '0;
  logic [7:0]        cfgValue;
  logic              txPush = 1'b0, txPop = 1'b0, rxPush = 1'b0, rxPop = 1'b0;
  logic [DATA_W-1:0] txPushData = '0, rxPushData = '0;
  logic [DATA_W-1:0] txPopData, rxPopData;
  logic              rxTimeout = 1'b0;
  logic [LVL_W-1:0]  txLevel, rxLevel;
  logic              txTrigHit, rxTrigHit, txRdyN, rxRdyN, txOverrun, rxOverrun;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_fifo_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_uart_fifo_ctrl (
    .clk (clk), .rstN (rstN), .cfgWrite (cfgWrite), .cfgData (cfgData),
    .cfgValue (cfgValue), .txPush (txPush), .txPushData (txPushData),
    .txPop (txPop), .txPopData (txPopData), .rxPush (rxPush),
    .rxPushData (rxPushData), .rxPop (rxPop), .rxPopData (rxPopData),
    .rxTimeout (rxTimeout), .txLevel (txLevel), .rxLevel (rxLevel),
    .txTrigHit (txTrigHit), .rxTrigHit (rxTrigHit), .txRdyN (txRdyN),
    .rxRdyN (rxRdyN), .txOverrun (txOverrun), .rxOverrun (rxOverrun)
  );

  typedef struct packed {
    logic [7:0] cfg;
    logic [7:0] rb;
    logic [7:0] rxT;
    logic [7:0] txT;
    logic       fill;
  } vec_t;

  // write byte, expected stored value, expected thresholds, whether to fill
  localparam vec_t VECS [7] = '{
    '{8'h01, 8'h01, 8'd8,  8'd8,  1'b1},
    '{8'h51, 8'h51, 8'd16, 8'd16, 1'b1},
    '{8'hA1, 8'hA1, 8'd56, 8'd32, 1'b1},
    '{8'hF9, 8'hF9, 8'd60, 8'd56, 1'b1},
    '{8'hF0, 8'hF8, 8'd0,  8'd0,  1'b0},
    '{8'h07, 8'h01, 8'd8,  8'd8,  1'b1},
    '{8'h6F, 8'h69, 8'd16, 8'd32, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Inputs change at the falling edge; results are read at the next falling edge.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeCfg(input logic [7:0] d);
    cfgWrite = 1'b1; cfgData = d;
    tick();
    cfgWrite = 1'b0; cfgData = '0;
  endtask

  task automatic pushRx(input int n, input int base);
    for (int k = 0; k < n; k++) begin
      rxPush = 1'b1; rxPushData = DATA_W'(base + k);
      tick();
    end
    rxPush = 1'b0;
  endtask

  task automatic pushTx(input int n, input int base);
    for (int k = 0; k < n; k++) begin
      txPush = 1'b1; txPushData = DATA_W'(base + k);
      tick();
    end
    txPush = 1'b0;
  endtask

  task automatic popRx(input int n);
    for (int k = 0; k < n; k++) begin
      rxPop = 1'b1;
      tick();
    end
    rxPop = 1'b0;
  endtask

  task automatic popTx(input int n);
    for (int k = 0; k < n; k++) begin
      txPop = 1'b1;
      tick();
    end
    txPop = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 cfgValue", cfgValue, 0);
    check("R1 rxLevel", rxLevel, 0);
    check("R1 txLevel", txLevel, 0);
    check("R1 rxRdyN", rxRdyN, 1);
    check("R1 txRdyN", txRdyN, 0);
    check("R1 overrun", {rxOverrun, txOverrun}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R11: disabled queues hold one character; second push overruns
    pushRx(2, 8'h40);
    check("R11 disabled capacity", rxLevel, 1);
    check("R11 rx overrun", rxOverrun, 1);
    check("R10 rxRdyN simple mode", rxRdyN, 0);
    popRx(1);
    check("R12 disabled pop data", rxPopData, 8'h40);
    check("R12 disabled pop level", rxLevel, 0);

    // Table walk over control byte decode and threshold edges
    for (int i = 0; i < 7; i++) begin
      writeCfg(VECS[i].cfg);
      check("R3 cfgValue", cfgValue, VECS[i].rb);
      if (i == 0) begin
        check("R5 enable clears rx", rxLevel, 0);
        check("R4 overrun cleared", rxOverrun, 0);
      end
      if (i == 4) check("R2 ignored write rb", cfgValue, 8'hF8);
      if (VECS[i].fill) begin
        pushRx(int'(VECS[i].rxT) - 1, 0);
        check("R6 rx below threshold", rxTrigHit, 0);
        pushRx(1, 0);
        check("R6 rx at threshold", rxTrigHit, 1);
        pushTx(DEPTH - int'(VECS[i].txT), 0);
        check("R7 tx free at threshold", txTrigHit, 1);
        pushTx(1, 0);
        check("R7 tx free below threshold", txTrigHit, 0);
        writeCfg(VECS[i].cfg | 8'h06);
        check("R4 rx cleared", rxLevel, 0);
        check("R4 tx cleared", txLevel, 0);
        check("R4 reset bits read 0", cfgValue, VECS[i].rb);
      end
    end

    // R12: order and registered pop data; simple-mode pins (R10)
    writeCfg(8'h01);
    pushTx(1, 8'hA5); pushTx(1, 8'h3C); pushTx(1, 8'h7E);
    popTx(1);
    check("R12 first out", txPopData, 8'hA5);
    popTx(1);
    check("R12 second out", txPopData, 8'h3C);
    check("R10 txRdyN nonempty", txRdyN, 1);
    popTx(1);
    check("R12 third out", txPopData, 8'h7E);
    check("R10 txRdyN empty", txRdyN, 0);
    popTx(1);
    check("R12 empty pop data", txPopData, 8'h7E);
    check("R12 empty pop level", txLevel, 0);

    // R13: simultaneous push and pop
    pushRx(1, 8'h11); pushRx(1, 8'h22);
    rxPush = 1'b1; rxPushData = 8'h33; rxPop = 1'b1;
    tick();
    rxPush = 1'b0; rxPop = 1'b0;
    check("R13 level", rxLevel, 2);
    check("R13 pop data", rxPopData, 8'h11);

    // R4: receive reset leaves transmit queue alone
    pushTx(3, 0);
    writeCfg(8'h03);
    check("R4 rx only cleared", rxLevel, 0);
    check("R4 tx untouched", txLevel, 3);

    // R11: overflow of an enabled queue
    writeCfg(8'h07);
    pushRx(DEPTH, 0);
    check("R11 full level", rxLevel, DEPTH);
    check("R11 no overrun yet", rxOverrun, 0);
    pushRx(1, 8'hEE);
    check("R11 dropped push", rxLevel, DEPTH);
    check("R11 overrun set", rxOverrun, 1);
    popRx(1);
    check("R12 oldest kept", rxPopData, 0);
    writeCfg(8'h03);
    check("R4 overrun cleared by reset bit", rxOverrun, 0);

    // R8: hysteretic receive pin, threshold 8
    writeCfg(8'h0F);
    pushRx(7, 0);
    check("R8 below threshold", rxRdyN, 1);
    pushRx(1, 0);
    check("R8 at threshold", rxRdyN, 0);
    popRx(5);
    check("R8 held while draining", rxRdyN, 0);
    popRx(3);
    check("R8 released at empty", rxRdyN, 1);
    pushRx(1, 0);
    check("R8 single char", rxRdyN, 1);
    rxTimeout = 1'b1; tick(); rxTimeout = 1'b0;
    check("R8 time-out asserts", rxRdyN, 0);
    popRx(1);
    check("R8 released after pop", rxRdyN, 1);
    rxTimeout = 1'b1; tick(); rxTimeout = 1'b0;
    check("R8 time-out on empty", rxRdyN, 1);

    // R9: hysteretic transmit pin, threshold 8
    pushTx(DEPTH - 1, 0);
    check("R9 not yet full", txRdyN, 0);
    pushTx(1, 0);
    check("R9 full", txRdyN, 1);
    popTx(7);
    check("R9 held with 7 free", txRdyN, 1);
    popTx(1);
    check("R9 released with 8 free", txRdyN, 0);

    // R10: back to simple pin mode keeps the level
    writeCfg(8'h01);
    check("R10 txRdyN simple", txRdyN, 1);

    // R5 and R2: disable write empties queues, programs nothing else
    writeCfg(8'h06);
    check("R5 disable clears tx", txLevel, 0);
    check("R2 disable rb", cfgValue, 8'h00);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule